// File: doc/BRIEF.md
# Set-Associative Cache Controller with LRU Replacement

This block sits between a processor that issues single-word reads and writes and a slower next-level memory that moves whole blocks. Each word address is split three ways. The low part picks a word inside a block, the middle part picks a set, and the remaining upper part is the tag. The tag is compared against every way of the chosen set at the same time. A hit is served from the local arrays. A miss fetches the block from memory, fills it into a way of the set and then completes the request.

Parameters set the number of ways, sets, words per block and the data and address widths. One way gives a direct-mapped cache. One set gives a fully associative cache. The write policy is fixed at elaboration. In write-through mode every write is forwarded to memory. In write-back mode writes stay local and set a dirty flag. A dirty line is copied back to memory before its slot is reused. Two counters report how many accepted requests hit and how many missed.

Top module: `setassoc_cache`

## Requirements
- R1: A word address `a` maps to offset `a mod WORDS`, set `(a / WORDS) mod SETS`, tag `a / (WORDS*SETS)`. The memory port carries block addresses equal to `a / WORDS`.
- R2: A read that hits raises `rsp_valid` for the cycle right after acceptance, returns the stored word, and adds one to `hit_count`.
- R3: A miss adds one to `miss_count` and issues a memory read of the request's block address. It responds only after that read is acknowledged, returning the fetched word.
- R4: On a miss, an invalid way of the set is filled before any valid line is replaced, lowest way number first. Blocks already resident stay resident.
- R5: When every way of the set is valid, the least recently used way is replaced. Read hits, write hits and fills all count as a use. With two ways, recency is one bit per set that names the next victim.
- R6: In write-through mode (`WRITE_BACK=0`), a write hit updates the cached word and also issues a memory write of the updated block to its block address. The response follows the acknowledge. A write miss fills the block first and then issues that write.
- R7: In write-back mode (`WRITE_BACK=1`), a write hit responds in the cycle after acceptance, makes no memory request, and marks the line dirty.
- R8: In write-back mode, a dirty victim is written to memory at its own block address, with its data, before the memory read that refills the slot.
- R9: Synchronous reset clears all valid, dirty and recency state and both counters. After reset every address misses.
- R10: `req_ready` is low while a miss or memory write is in progress. A memory request holds its address, direction and data until `mem_ack`. Only one memory request is outstanding at a time.
- R11: With 2 ways, 2 sets and 1-word blocks, the read sequence 0,2,0,1,4,0,2,3,5,4 gives miss, miss, hit, miss, miss, hit, miss, miss, miss, miss. That is 2 hits and 8 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data (write data echoed for writes) |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W | Block address |
| mem_wdata | output | WORDS*DATA_W | Block written to memory |
| mem_rdata | input | WORDS*DATA_W | Block returned, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the request |
| hit_count | output | CNT_W | Accepted requests that hit |
| miss_count | output | CNT_W | Accepted requests that missed |

## Verification
A corrupted tag, valid bit or recency bit shows up at the ports as a hit/miss flip. That flip is visible at once as a latency change and a counter step. It also tends to surface a few accesses later, because the wrong line is evicted and a later access to it misses. A lost dirty flag shows only when that line is evicted: the write-back never appears on the memory port, and the next refill of the address returns stale data. A wrong victim choice is exposed by the fixed ten-access sequence, whose hit pattern depends on every replacement decision.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_WT   = 2'd3
    } ctl_state_e;

    function automatic int unsigned idx_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sa_way_match.sv
module sa_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic [WAYS-1:0]             match_o,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            way_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |match_o;

endmodule

// File: rtl/sa_recency.sv
module sa_recency #(
    parameter int WAYS  = 2,
    parameter int SETS  = 2,
    parameter int SET_W = 1,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] victim
);

    if (WAYS == 1) begin : g_dm
        assign victim = '0;
    end else if (WAYS == 2) begin : g_bit
        logic [SETS-1:0] rec_d, rec_q;

        always_comb begin
            rec_d = rec_q;
            if (touch_en) rec_d[touch_set] = ~touch_way[0];
        end

        always_ff @(posedge clk) begin
            if (rst) rec_q <= '0;
            else     rec_q <= rec_d;
        end

        assign victim = WAY_W'(rec_q[look_set]);

        // R5: a way just used is never the next victim of its set
        a_r5_touched_not_victim: assert property (@(posedge clk) disable iff (rst)
            touch_en |=> (rec_q[$past(touch_set)] != $past(touch_way[0])));
    end else begin : g_age
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;

        always_comb begin
            age_d = age_q;
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                        age_d[touch_set][w] = age_q[touch_set][w] + WAY_W'(1);
                end
                age_d[touch_set][touch_way] = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[s][w] <= WAY_W'(w);
            end else begin
                age_q <= age_d;
            end
        end

        always_comb begin
            victim = '0;
            for (int w = 0; w < WAYS; w++)
                if (age_q[look_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache
    import sa_cache_pkg::*;
#(
    parameter int WAYS       = 2,
    parameter int SETS       = 2,
    parameter int WORDS      = 1,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int WRITE_BACK = 1,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_we,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS*DATA_W-1:0] mem_wdata,
    input  logic [WORDS*DATA_W-1:0] mem_rdata,
    input  logic                    mem_ack,
    output logic [CNT_W-1:0]        hit_count,
    output logic [CNT_W-1:0]        miss_count
);

    localparam int BLK_W = WORDS * DATA_W;
    localparam int SET_W = idx_bits(SETS);
    localparam int WAY_W = idx_bits(WAYS);
    localparam int OFF_W = idx_bits(WORDS);

    typedef struct packed {
        ctl_state_e                              st;
        logic [ADDR_W-1:0]                       addr;
        logic                                    we;
        logic [DATA_W-1:0]                       wdata;
        logic [WAY_W-1:0]                        way;
        logic                                    rsp_valid;
        logic [DATA_W-1:0]                       rdata;
        logic                                    mreq;
        logic                                    mwe;
        logic [ADDR_W-1:0]                       maddr;
        logic [BLK_W-1:0]                        mwdata;
        logic [CNT_W-1:0]                        hits;
        logic [CNT_W-1:0]                        misses;
        logic [SETS-1:0][WAYS-1:0]               valid;
        logic [SETS-1:0][WAYS-1:0]               dirty;
        logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0]   tags;
        logic [SETS-1:0][WAYS-1:0][BLK_W-1:0]    data;
    } ctl_t;

    ctl_t d, q;

    // address split of the request in IDLE, of the held request otherwise
    logic [ADDR_W-1:0] lk_addr, lk_blk, lk_tag;
    logic [SET_W-1:0]  lk_set;
    logic [OFF_W-1:0]  lk_off;

    assign lk_addr = (q.st == ST_IDLE) ? req_addr : q.addr;
    assign lk_blk  = lk_addr / ADDR_W'(WORDS);
    assign lk_set  = SET_W'(lk_blk % ADDR_W'(SETS));
    assign lk_tag  = lk_blk / ADDR_W'(SETS);
    assign lk_off  = OFF_W'(lk_addr % ADDR_W'(WORDS));

    logic [WAYS-1:0]  match_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way;

    sa_way_match #(.WAYS(WAYS), .TAG_W(ADDR_W), .WAY_W(WAY_W)) u_match (
        .valid_i (q.valid[lk_set]),
        .tags_i  (q.tags[lk_set]),
        .tag_i   (lk_tag),
        .match_o (match_vec),
        .hit_o   (hit),
        .way_o   (hit_way)
    );

    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic [WAY_W-1:0] lru_way;

    sa_recency #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_recency (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_set (lk_set),
        .touch_way (touch_way),
        .look_set  (lk_set),
        .victim    (lru_way)
    );

    // lowest-numbered empty way wins over the recency choice
    logic             any_free;
    logic [WAY_W-1:0] free_way, vict_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!q.valid[lk_set][w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        vict_way = any_free ? free_way : lru_way;
    end

    always_comb begin
        logic [BLK_W-1:0] blk;
        d         = q;
        d.rsp_valid = 1'b0;
        touch_en  = 1'b0;
        touch_way = '0;
        blk       = '0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit) begin
                        d.hits    = q.hits + CNT_W'(1);
                        touch_en  = 1'b1;
                        touch_way = hit_way;
                        blk       = q.data[lk_set][hit_way];
                        if (!req_we) begin
                            d.rsp_valid = 1'b1;
                            d.rdata     = blk[lk_off*DATA_W +: DATA_W];
                        end else begin
                            blk[lk_off*DATA_W +: DATA_W] = req_wdata;
                            d.data[lk_set][hit_way] = blk;
                            d.rdata = req_wdata;
                            if (WRITE_BACK != 0) begin
                                d.dirty[lk_set][hit_way] = 1'b1;
                                d.rsp_valid = 1'b1;
                            end else begin
                                d.st     = ST_WT;
                                d.wdata  = req_wdata;
                                d.mreq   = 1'b1;
                                d.mwe    = 1'b1;
                                d.maddr  = lk_blk;
                                d.mwdata = blk;
                            end
                        end
                    end else begin
                        d.misses = q.misses + CNT_W'(1);
                        d.addr   = req_addr;
                        d.we     = req_we;
                        d.wdata  = req_wdata;
                        d.way    = vict_way;
                        d.mreq   = 1'b1;
                        if ((WRITE_BACK != 0) && q.valid[lk_set][vict_way]
                                && q.dirty[lk_set][vict_way]) begin
                            d.st     = ST_WB;
                            d.mwe    = 1'b1;
                            d.maddr  = q.tags[lk_set][vict_way] * ADDR_W'(SETS)
                                       + ADDR_W'(lk_set);
                            d.mwdata = q.data[lk_set][vict_way];
                        end else begin
                            d.st    = ST_FILL;
                            d.mwe   = 1'b0;
                            d.maddr = lk_blk;
                        end
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    d.st    = ST_FILL;
                    d.mreq  = 1'b1;
                    d.mwe   = 1'b0;
                    d.maddr = lk_blk;
                    d.dirty[lk_set][q.way] = 1'b0;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    blk = mem_rdata;
                    if (q.we) blk[lk_off*DATA_W +: DATA_W] = q.wdata;
                    d.data[lk_set][q.way]  = blk;
                    d.tags[lk_set][q.way]  = lk_tag;
                    d.valid[lk_set][q.way] = 1'b1;
                    d.dirty[lk_set][q.way] = (WRITE_BACK != 0) && q.we;
                    touch_en  = 1'b1;
                    touch_way = q.way;
                    d.rdata   = blk[lk_off*DATA_W +: DATA_W];
                    if (q.we && (WRITE_BACK == 0)) begin
                        d.st     = ST_WT;
                        d.mreq   = 1'b1;
                        d.mwe    = 1'b1;
                        d.maddr  = lk_blk;
                        d.mwdata = blk;
                    end else begin
                        d.st        = ST_IDLE;
                        d.mreq      = 1'b0;
                        d.rsp_valid = 1'b1;
                    end
                end
            end
            ST_WT: begin
                if (mem_ack) begin
                    d.st        = ST_IDLE;
                    d.mreq      = 1'b0;
                    d.rsp_valid = 1'b1;
                    d.rdata     = q.wdata;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_rdata  = q.rdata;
    assign mem_req    = q.mreq;
    assign mem_we     = q.mwe;
    assign mem_addr   = q.maddr;
    assign mem_wdata  = q.mwdata;
    assign hit_count  = q.hits;
    assign miss_count = q.misses;

    // R10: the processor side is closed while memory is busy
    a_r10_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && mem_req));

    // R10: a pending memory request is held until acknowledged
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R2: an accepted read hit completes in the next cycle
    a_r2_hit_next: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && hit && !req_we) |=> rsp_valid);

    // R7: write-back hits never touch memory
    a_r7_wb_quiet: assert property (@(posedge clk) disable iff (rst)
        ((WRITE_BACK != 0) && req_valid && req_ready && hit) |=> (!mem_req && rsp_valid));

    // R4: a block is resident in at most one way of its set
    a_r4_single_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

endmodule

// File: tb/setassoc_cache_bench.sv
module sa_bench_mem #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [BLK_W-1:0]  mem_wdata,
    output logic [BLK_W-1:0]  mem_rdata,
    output logic              mem_ack
);
    logic [BLK_W-1:0] store [2**ADDR_W];
    int               wait_cnt = 0;
    int               wr_cnt = 0;
    int               rd_cnt = 0;
    logic [ADDR_W-1:0] last_waddr = '0;
    logic [ADDR_W-1:0] last_raddr = '0;
    logic [BLK_W-1:0]  last_wdata = '0;
    logic [1:0]        hist = '0;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < 2**ADDR_W; i++) store[i] = BLK_W'(i * 7 + 'h300);
    end

    always @(posedge clk) begin
        if (!mem_req || mem_ack) begin
            wait_cnt <= 0;
            mem_ack  <= 1'b0;
        end else if (wait_cnt < 2) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            mem_ack <= 1'b1;
            hist    <= {hist[0], mem_we};
            if (mem_we) begin
                store[mem_addr] <= mem_wdata;
                wr_cnt     <= wr_cnt + 1;
                last_waddr <= mem_addr;
                last_wdata <= mem_wdata;
            end else begin
                mem_rdata  <= store[mem_addr];
                rd_cnt     <= rd_cnt + 1;
                last_raddr <= mem_addr;
            end
        end
    end
endmodule

module setassoc_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    // {expected hit, address} for the fixed replacement sequence (R11)
    localparam logic [8:0] SEQ [10] = '{
        9'h000, 9'h002, 9'h100, 9'h001, 9'h004,
        9'h100, 9'h002, 9'h003, 9'h005, 9'h004
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rv = 1'b0;
    int            sel = 0;
    logic [AW-1:0] raddr = '0;
    logic          rwe = 1'b0;
    logic [DW-1:0] rwdata = '0;

    logic          a_ready, b_ready, a_rsp, b_rsp;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_mreq, b_mreq, a_mwe, b_mwe, a_ack, b_ack;
    logic [AW-1:0] a_maddr, b_maddr;
    logic [DW-1:0] a_mwdata, b_mwdata, a_mrdata, b_mrdata;
    logic [15:0]   a_hits, b_hits, a_miss, b_miss;

    setassoc_cache #(.WRITE_BACK(1)) u_setassoc_cache (
        .clk(clk), .rst(rst), .req_valid(rv && sel == 0), .req_ready(a_ready),
        .req_addr(raddr), .req_we(rwe), .req_wdata(rwdata),
        .rsp_valid(a_rsp), .rsp_rdata(a_rdata),
        .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr), .mem_wdata(a_mwdata),
        .mem_rdata(a_mrdata), .mem_ack(a_ack), .hit_count(a_hits), .miss_count(a_miss)
    );

    setassoc_cache #(.WRITE_BACK(0)) u_wt (
        .clk(clk), .rst(rst), .req_valid(rv && sel == 1), .req_ready(b_ready),
        .req_addr(raddr), .req_we(rwe), .req_wdata(rwdata),
        .rsp_valid(b_rsp), .rsp_rdata(b_rdata),
        .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwdata),
        .mem_rdata(b_mrdata), .mem_ack(b_ack), .hit_count(b_hits), .miss_count(b_miss)
    );

    sa_bench_mem #(.ADDR_W(AW), .BLK_W(DW)) m_a (
        .clk(clk), .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr),
        .mem_wdata(a_mwdata), .mem_rdata(a_mrdata), .mem_ack(a_ack));
    sa_bench_mem #(.ADDR_W(AW), .BLK_W(DW)) m_b (
        .clk(clk), .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr),
        .mem_wdata(b_mwdata), .mem_rdata(b_mrdata), .mem_ack(b_ack));

    wire          ready = (sel == 1) ? b_ready : a_ready;
    wire          rsp   = (sel == 1) ? b_rsp   : a_rsp;
    wire [DW-1:0] rdata = (sel == 1) ? b_rdata : a_rdata;

    int checks = 0;
    int fails  = 0;

    function automatic logic [DW-1:0] init_word(int a);
        return DW'(a * 7 + 'h300);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat, output logic busy);
        @(negedge clk);
        raddr = a; rwe = we; rwdata = wd; rv = 1'b1;
        while (!ready) @(negedge clk);
        @(negedge clk);
        rv = 1'b0;
        busy = !ready;
        lat = 1;
        while (!rsp) begin
            @(negedge clk);
            lat++;
        end
        rd = rdata;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        int lat, h0, m0, w0;
        logic busy;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9", "ready after reset", a_ready, 1);
        chk("R9", "rsp after reset", a_rsp, 0);
        chk("R9", "mem_req after reset", a_mreq, 0);
        chk("R9", "counts after reset", a_hits + a_miss, 0);

        // R11 / R1 / R2 / R3 / R5: fixed sequence
        for (int i = 0; i < 10; i++) begin
            h0 = a_hits; m0 = a_miss;
            access(SEQ[i][7:0], 1'b0, '0, rd, lat, busy);
            chk("R11", $sformatf("hit step %0d", i), a_hits - h0, SEQ[i][8]);
            chk("R3", $sformatf("miss step %0d", i), a_miss - m0, !SEQ[i][8]);
            chk("R2", $sformatf("read data %0d", i), rd, init_word(SEQ[i][7:0]));
            if (SEQ[i][8]) chk("R2", "hit latency", lat, 1);
            else chk("R1", "fetch block address", m_a.last_raddr, SEQ[i][7:0]);
        end
        chk("R11", "total hits", a_hits, 2);
        chk("R11", "total misses", a_miss, 8);

        // R7: write hit in write-back mode stays local
        w0 = m_a.wr_cnt; h0 = a_hits;
        access(8'd4, 1'b1, 16'hBEEF, rd, lat, busy);
        chk("R7", "write hit latency", lat, 1);
        chk("R7", "no memory write", m_a.wr_cnt, w0);
        chk("R7", "write counted as hit", a_hits - h0, 1);
        access(8'd4, 1'b0, '0, rd, lat, busy);
        chk("R7", "read back dirty word", rd, 16'hBEEF);

        // R8: clean eviction, then dirty eviction
        access(8'd6, 1'b0, '0, rd, lat, busy);
        chk("R8", "clean victim not written", m_a.wr_cnt, w0);
        access(8'd8, 1'b0, '0, rd, lat, busy);
        chk("R10", "ready low during miss", busy, 1);
        chk("R8", "dirty victim written", m_a.wr_cnt, w0 + 1);
        chk("R8", "victim block address", m_a.last_waddr, 4);
        chk("R8", "victim data", m_a.last_wdata, 16'hBEEF);
        chk("R8", "write before refill", m_a.hist, 2'b10);
        chk("R3", "refill data", rd, init_word(8));
        access(8'd4, 1'b0, '0, rd, lat, busy);
        chk("R8", "memory holds written-back word", rd, 16'hBEEF);

        // R9: reset drops cached lines
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R9", "counts cleared", a_hits + a_miss, 0);
        access(8'd0, 1'b0, '0, rd, lat, busy);
        chk("R9", "cached address misses after reset", a_miss, 1);

        // R4: empty way used, resident block kept
        access(8'd2, 1'b0, '0, rd, lat, busy);
        access(8'd0, 1'b0, '0, rd, lat, busy);
        chk("R4", "first block still resident", lat, 1);
        access(8'd2, 1'b0, '0, rd, lat, busy);
        chk("R4", "second block resident", lat, 1);

        // R6: write-through instance
        sel = 1;
        access(8'd10, 1'b0, '0, rd, lat, busy);
        w0 = m_b.wr_cnt; h0 = b_hits;
        access(8'd10, 1'b1, 16'h1234, rd, lat, busy);
        chk("R6", "write hit counted", b_hits - h0, 1);
        chk("R6", "memory write issued", m_b.wr_cnt, w0 + 1);
        chk("R6", "write block address", m_b.last_waddr, 10);
        chk("R6", "write data", m_b.last_wdata, 16'h1234);
        chk("R6", "response after ack", lat > 1, 1);
        access(8'd10, 1'b0, '0, rd, lat, busy);
        chk("R6", "cache updated", rd, 16'h1234);
        chk("R6", "read hit latency", lat, 1);
        access(8'd12, 1'b1, 16'h5555, rd, lat, busy);
        chk("R6", "write miss: fill then write", m_b.hist, 2'b01);
        chk("R6", "write miss data", m_b.last_wdata, 16'h5555);

        finish_run();
    end

endmodule